// File: doc/BRIEF.md
# Power-Good Window Monitor

This block watches a digitised feedback voltage, expressed as a fraction of the regulator reference, and decides whether a power-good flag should be raised. The feedback code is unsigned and scaled so that 1000 stands for 100% of the reference. A voltage is accepted only after it has sat inside an inner band for a programmable time. A voltage outside a wider outer band drops the flag on the next clock edge. Between the inner and outer bands the monitor keeps whatever state it already had, so a supply that rings near a limit does not make the flag chatter.

The assertion delay is counted in microsecond ticks from a free-running tick input. A 3-bit select picks the delay. The lower seven codes double a base period, starting at 256 µs. The top code jumps to a much longer delay of 512 base periods (about 131 ms). The select is captured when a count starts, so a change made during a count only takes effect on the next count. An enable input, driven high once soft-start has finished, gates the whole function. The comparators, the output pull-down and any register access sit outside this block.

Top module: `pgood_mon`

## Requirements
- R1: While `ssDone` is low, `pgFlag` is 0 from the clock edge that samples it, and the timer is cleared. After `ssDone` returns high, the full selected delay must elapse again. `pgFlag` is 0 during and right after reset.
- R2: The monitor enters the window when `fbCode` is in the inner band, 920 to 1080 inclusive. This applies whether the code comes from below or from above the band.
- R3: If the clock edge samples `fbCode` above 1160 or below 840, `pgFlag` is 0 after that edge.
- R4: Codes 840 to 919 and 1081 to 1160 form the hysteresis band. There, the in-window state and `pgFlag` keep their last value: a raised flag stays raised, and a monitor that is out of the window does not enter it.
- R5: Delay select code k (0 to 6) gives a delay of BASE_TICKS·2^k ticks. Code 7 gives BASE_TICKS·512 ticks. The edge that first samples the window opened starts the count. `pgFlag` rises on the edge that samples the last tick of the delay.
- R6: If the window is lost before the delay has expired, the timer restarts from zero at the next entry.
- R7: A change to `dlySel` while a count is running does not change that count. The new value is used from the next restart.
- R8: Only cycles with `usTick` high advance the timer. With no ticks, `pgFlag` stays 0 indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| usTick | input | 1 | One-cycle pulse per microsecond |
| fbCode | input | CODE_W (11) | Feedback as per-mille of reference |
| dlySel | input | DLY_W (3) | Assertion delay select |
| ssDone | input | 1 | Enable; high once soft-start has finished |
| pgFlag | output | 1 | Power-good flag, high = good |

## Verification
The hardest situation to reach from the ports is a count interrupted late. That happens when the window is lost after most of the delay has passed, or when the select changes while a count is running. Random feedback seldom dwells long enough for either. Directed sequences therefore step out of the window one tick-count before expiry, or rewrite `dlySel` partway through a count, and then measure the cycle of the next rise. A reduced BASE_TICKS keeps even the long top code within reach. Random stimulus then clusters feedback codes on each threshold and its neighbours, with random tick gaps and enable dropouts, against a cycle-level model.

// File: rtl/pgood_pkg.sv
package pgood_pkg;
  // Strobes from the control FSM to the timer datapath.
  typedef struct packed {
    logic clr;   // zero the count
    logic load;  // zero the count and capture the delay limit
    logic inc;   // advance the count by one tick
  } pgStrobe_t;
endpackage

// File: rtl/pgood_dp.sv
module pgood_dp
  import pgood_pkg::*;
#(
  parameter int CODE_W     = 11,
  parameter int DLY_W      = 3,
  parameter int LO_OUT     = 840,
  parameter int LO_IN      = 920,
  parameter int HI_IN      = 1080,
  parameter int HI_OUT     = 1160,
  parameter int BASE_TICKS = 256,
  parameter int LONG_SHIFT = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] fbCode,
  input  logic [DLY_W-1:0]  dlySel,
  input  pgStrobe_t         strobe,
  output logic              isInner,
  output logic              isOuter,
  output logic              lastTick
);
  localparam int NUM_CODES = 1 << DLY_W;
  localparam int LONGEST   = BASE_TICKS << LONG_SHIFT;
  localparam int CNT_W     = $clog2(LONGEST + 1);

  logic [CNT_W-1:0] limTab [NUM_CODES];
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] tickLim;

  // Delay table: doubling steps, with the top code breaking the pattern.
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_lim
    if (g == NUM_CODES - 1) begin : g_long
      assign limTab[g] = CNT_W'(LONGEST);
    end else begin : g_step
      assign limTab[g] = CNT_W'(BASE_TICKS << g);
    end
  end

  // Window classification of the current sample.
  assign isInner = (fbCode >= CODE_W'(LO_IN)) && (fbCode <= CODE_W'(HI_IN));
  assign isOuter = (fbCode > CODE_W'(HI_OUT)) || (fbCode < CODE_W'(LO_OUT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      tickLim <= '0;
    end else if (strobe.load) begin
      tickCnt <= '0;
      tickLim <= limTab[dlySel];
    end else if (strobe.clr) begin
      tickCnt <= '0;
    end else if (strobe.inc) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assign lastTick = ({1'b0, tickCnt} + 1'b1) == {1'b0, tickLim};
endmodule

// File: rtl/pgood_ctl.sv
module pgood_ctl
  import pgood_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ssDone,
  input  logic      usTick,
  input  logic      isInner,
  input  logic      isOuter,
  input  logic      lastTick,
  output pgStrobe_t strobe,
  output logic      pgFlag
);
  logic winReg;
  logic runReg;
  logic pgReg;
  logic winNext;
  logic armed;

  // Hysteresis: inner band sets, outer region clears, band between holds.
  always_comb begin
    if (isInner)      winNext = 1'b1;
    else if (isOuter) winNext = 1'b0;
    else              winNext = winReg;
  end

  assign armed = ssDone && winNext;

  always_comb begin
    strobe = '0;
    if (!armed)                                strobe.clr  = 1'b1;
    else if (!runReg)                          strobe.load = 1'b1;
    else if (!pgReg && usTick && !lastTick)    strobe.inc  = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winReg <= 1'b0;
      runReg <= 1'b0;
      pgReg  <= 1'b0;
    end else begin
      winReg <= winNext;
      runReg <= armed;
      if (!armed)                           pgReg <= 1'b0;
      else if (runReg && usTick && lastTick) pgReg <= 1'b1;
    end
  end

  assign pgFlag = pgReg;
endmodule

// File: rtl/pgood_mon.sv
module pgood_mon
  import pgood_pkg::*;
#(
  parameter int CODE_W     = 11,
  parameter int DLY_W      = 3,
  parameter int LO_OUT     = 840,
  parameter int LO_IN      = 920,
  parameter int HI_IN      = 1080,
  parameter int HI_OUT     = 1160,
  parameter int BASE_TICKS = 256,
  parameter int LONG_SHIFT = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic [CODE_W-1:0] fbCode,
  input  logic [DLY_W-1:0]  dlySel,
  input  logic              ssDone,
  output logic              pgFlag
);
  pgStrobe_t strobe;
  logic      isInner;
  logic      isOuter;
  logic      lastTick;

  pgood_dp #(
    .CODE_W(CODE_W), .DLY_W(DLY_W),
    .LO_OUT(LO_OUT), .LO_IN(LO_IN), .HI_IN(HI_IN), .HI_OUT(HI_OUT),
    .BASE_TICKS(BASE_TICKS), .LONG_SHIFT(LONG_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .fbCode(fbCode), .dlySel(dlySel),
    .strobe(strobe), .isInner(isInner), .isOuter(isOuter), .lastTick(lastTick)
  );

  pgood_ctl u_ctl (
    .clk(clk), .rstN(rstN), .ssDone(ssDone), .usTick(usTick),
    .isInner(isInner), .isOuter(isOuter), .lastTick(lastTick),
    .strobe(strobe), .pgFlag(pgFlag)
  );
endmodule

// File: rtl/pgood_mon_chk.sv
module pgood_mon_chk #(
  parameter int CODE_W = 11,
  parameter int LO_OUT = 840,
  parameter int HI_OUT = 1160
) (
  input logic              clk,
  input logic              rstN,
  input logic              usTick,
  input logic [CODE_W-1:0] fbCode,
  input logic              ssDone,
  input logic              pgFlag
);
  logic outside;
  assign outside = (fbCode > CODE_W'(HI_OUT)) || (fbCode < CODE_W'(LO_OUT));

  AST_EN_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !ssDone |=> !pgFlag); // R1

  AST_RISE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgFlag) |-> ($past(ssDone) && !$past(outside))); // R2

  AST_OUT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    outside |=> !pgFlag); // R3

  AST_HOLD_IN_BAND: assert property (@(posedge clk) disable iff (!rstN)
    (pgFlag && ssDone && !outside) |=> pgFlag); // R4

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgFlag) |-> $past(usTick)); // R8
endmodule

bind pgood_mon pgood_mon_chk #(
  .CODE_W(CODE_W), .LO_OUT(LO_OUT), .HI_OUT(HI_OUT)
) u_chk (
  .clk(clk), .rstN(rstN), .usTick(usTick), .fbCode(fbCode),
  .ssDone(ssDone), .pgFlag(pgFlag)
);

// File: tb/pgood_mon_bench.sv
module pgood_mon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        usTick = 1'b0;
  logic [10:0] fbCode = '0;
  logic [2:0]  dlySel = '0;
  logic        ssDone = 1'b0;
  logic        pgFlag;

  int checks = 0;
  int fails  = 0;
  int tickMode = 1;      // 0 none, 1 every cycle, 2 random
  bit compareOn = 1'b0;
  bit finished = 1'b0;
  string phaseTag = "R1";

  pgood_mon #(.BASE_TICKS(BASE)) u_pgood_mon (
    .clk(clk), .rstN(rstN), .usTick(usTick), .fbCode(fbCode),
    .dlySel(dlySel), .ssDone(ssDone), .pgFlag(pgFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Delay in ticks per R5.
  function automatic int limOf(input int code);
    return (code == 7) ? (BASE << 9) : (BASE << code);
  endfunction
  function automatic bit inInner(input int v);
    return (v >= 920) && (v <= 1080);
  endfunction
  function automatic bit inOuter(input int v);
    return (v > 1160) || (v < 840);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-level expectation built from R1..R8.
  bit mWin, mRun, mPg;
  int mCnt, mLim;
  always @(posedge clk) begin
    if (!rstN) begin
      mWin = 0; mRun = 0; mPg = 0; mCnt = 0; mLim = 0;
    end else begin
      if (inInner(int'(fbCode))) mWin = 1;
      else if (inOuter(int'(fbCode))) mWin = 0;
      if (!ssDone || !mWin) begin
        mRun = 0; mCnt = 0; mPg = 0;
      end else if (!mRun) begin
        mRun = 1; mCnt = 0; mLim = limOf(int'(dlySel));
      end else if (!mPg && usTick) begin
        if (mCnt + 1 == mLim) mPg = 1;
        else mCnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (compareOn) check(pgFlag == mPg, phaseTag, int'(pgFlag), int'(mPg));
    case (tickMode)
      0: usTick <= 1'b0;
      1: usTick <= 1'b1;
      default: usTick <= 1'($urandom % 2);
    endcase
  end

  task automatic stepN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Leave window via prefill, then enter with fbv; count negedges to rise.
  task automatic measure(input int sel, input int prefill, input int fbv,
                         input int maxN, output int n);
    @(negedge clk); fbCode = 11'(prefill);
    @(negedge clk); dlySel = 3'(sel); fbCode = 11'(fbv);
    n = 0;
    do begin @(negedge clk); n++; end while (!pgFlag && n < maxN);
  endtask

  int n;
  bit stayed;

  initial begin
    void'($urandom(32'h0005_eed1));
    stepN(3);
    check(pgFlag == 1'b0, "R1 reset", int'(pgFlag), 0);
    rstN = 1'b1;
    stepN(1);
    check(pgFlag == 1'b0, "R1 after reset", int'(pgFlag), 0);
    ssDone = 1'b1;
    compareOn = 1'b1;

    // R5: every delay code
    phaseTag = "R5";
    for (int c = 0; c < 8; c++) begin
      measure(c, 0, 1000, 3000, n);
      check(n == limOf(c) + 1, $sformatf("R5 code %0d", c), n, limOf(c) + 1);
    end

    // R2: inclusive inner edges from below and above
    phaseTag = "R2";
    measure(0, 0, 920, 200, n);
    check(n == 5, "R2 enter from below at 920", n, 5);
    measure(0, 2000, 1080, 200, n);
    check(n == 5, "R2 enter from above at 1080", n, 5);

    // R4: band does not enter
    phaseTag = "R4";
    measure(0, 0, 919, 50, n);
    check(pgFlag == 1'b0, "R4 919 from below no entry", int'(pgFlag), 0);
    measure(0, 2000, 1081, 50, n);
    check(pgFlag == 1'b0, "R4 1081 from above no entry", int'(pgFlag), 0);
    // R4: band holds a raised flag
    measure(0, 0, 1000, 200, n);
    @(negedge clk); fbCode = 11'd1160;
    stepN(40);
    check(pgFlag == 1'b1, "R4 hold at 1160", int'(pgFlag), 1);
    fbCode = 11'd840;
    stepN(40);
    check(pgFlag == 1'b1, "R4 hold at 840", int'(pgFlag), 1);

    // R3: immediate drop past outer thresholds
    phaseTag = "R3";
    fbCode = 11'd1161;
    stepN(1);
    check(pgFlag == 1'b0, "R3 drop at 1161", int'(pgFlag), 0);
    measure(0, 0, 1000, 200, n);
    @(negedge clk); fbCode = 11'd839;
    stepN(1);
    check(pgFlag == 1'b0, "R3 drop at 839", int'(pgFlag), 0);

    // R6: lose window late in a count, timer restarts
    phaseTag = "R6";
    @(negedge clk); fbCode = 11'd0; dlySel = 3'd2;
    @(negedge clk); fbCode = 11'd1000;
    stayed = 1'b1;
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (pgFlag) stayed = 1'b0; end
    fbCode = 11'd839;
    @(negedge clk); fbCode = 11'd1000;
    n = 0;
    do begin @(negedge clk); n++; end while (!pgFlag && n < 200);
    check(stayed, "R6 no rise before loss", int'(!stayed), 0);
    check(n == 17, "R6 full delay after re-entry", n, 17);

    // R7: select change mid-count applies at next restart
    phaseTag = "R7";
    @(negedge clk); fbCode = 11'd0; dlySel = 3'd1;
    @(negedge clk); fbCode = 11'd1000;
    n = 0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); n++; end
    dlySel = 3'd3;
    do begin @(negedge clk); n++; end while (!pgFlag && n < 200);
    check(n == 9, "R7 running count keeps old select", n, 9);
    measure(3, 0, 1000, 200, n);
    check(n == 33, "R7 new select after restart", n, 33);

    // R8: no ticks, no rise
    phaseTag = "R8";
    tickMode = 0;
    @(negedge clk); fbCode = 11'd0; dlySel = 3'd0;
    @(negedge clk); fbCode = 11'd1000;
    stepN(100);
    check(pgFlag == 1'b0, "R8 no ticks keeps flag low", int'(pgFlag), 0);
    tickMode = 1;
    stepN(10);
    check(pgFlag == 1'b1, "R8 ticks resume count", int'(pgFlag), 1);

    // R1: enable drop clears flag and timer
    phaseTag = "R1";
    @(negedge clk); ssDone = 1'b0;
    @(negedge clk);
    check(pgFlag == 1'b0, "R1 enable low drops flag", int'(pgFlag), 0);
    stepN(5);
    ssDone = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!pgFlag && n < 200);
    check(n == 5, "R1 full delay after enable", n, 5);

    // Random mix around thresholds (R2,R3,R4,R5,R8)
    phaseTag = "R4 random";
    tickMode = 2;
    for (int k = 0; k < 400; k++) begin
      int pick;
      int v;
      pick = int'($urandom % 14);
      case (pick)
        0: v = 839;  1: v = 840;  2: v = 841;  3: v = 919;
        4: v = 920;  5: v = 921;  6: v = 1000; 7: v = 1079;
        8: v = 1080; 9: v = 1081; 10: v = 1160; 11: v = 1161;
        default: v = int'($urandom % 2048);
      endcase
      @(negedge clk);
      fbCode = 11'(v);
      if ($urandom % 4 == 0) dlySel = 3'($urandom % 4);
      ssDone = ($urandom % 32) != 0;
      stepN(1 + int'($urandom % 40));
    end
    compareOn = 1'b0;

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule